// File: doc/BRIEF.md
# Keyboard and display scan controller

This block scans an 8 by 8 key matrix and drives a multiplexed numeric display from one shared column counter. Each column stays selected for a fixed number of clock cycles. While a column is selected, the block reads the return lines for that column and presents the byte for that digit from a small display memory, split into two 4-bit halves.

Keys that stay closed long enough are encoded into a byte. Each byte carries the shift and control inputs and the key's position, and goes into an eight-entry first-in first-out queue. A new key raises an interrupt request.

A host reaches the block through a byte-wide port with chip select, read and write strobes, and a command/data select. Through this port it:

- sets the scan form and the digit count,
- picks what data reads return,
- loads the display memory,
- masks or blanks half-digits,
- clears the memory or the queue,
- acknowledges the interrupt.

A read with the select high returns a status byte that gives the queue fill level and an overrun flag.

Top module: `kbd_disp_scanner`

## Requirements
- R1: After reset, `scan_o` is 0 (encoded form, column 0), `irq_o` is 0, the status byte is 0x00 and both display nibble outputs are 0.
- R2: The column advances by one every 4 clock cycles. In encoded form `scan_o[2:0]` holds the column number. Mode byte bit 0 set gives decoded form, where `scan_o` is one-hot on the column. Mode bits 4:3 equal to 01 limit the scan to columns 0 to 3; any other value scans all 8 columns.
- R3: A return line reads low when its key is closed. A key is queued only after it is seen closed on two consecutive visits of its column. A held key is queued once, and is queued again only after it has been seen open.
- R4: The byte for a queued key is laid out as follows: bit 7 is shift, bit 6 is control, bits 5:3 are the column, and bits 2:0 are the lowest closed return-line index. At most one key is queued per column visit, so several closed keys in one column are queued lowest index first.
- R5: The queue holds 8 bytes in arrival order. With the queue selected, a data read returns the oldest byte and removes it. A data read of an empty queue returns 0x00 and changes nothing.
- R6: The status byte carries the overrun flag in bit 7 and the fill count in bits 3:0. A key arriving while the queue is full is dropped and sets overrun. Only a queue clear resets overrun.
- R7: `irq_o` is set when a key is queued. It stays set through data reads. It is cleared by the end-interrupt command or by a queue clear.
- R8: Command writes (select high) decode bits 7:5 as the opcode: 000 mode, 001 select queue reads, 010 select display reads, 011 display write address, 100 mask and blank, 101 clear, 110 end interrupt. Opcode 111 changes nothing.
- R9: Opcode 011 sets the write address from bits 2:0, and bit 4 enables auto-increment. Each data write stores a byte at that address. When the scan reaches that column, the high nibble of the byte appears on `disp_hi_o` and the low nibble on `disp_lo_o`.
- R10: Opcode 100 sets four flags. Bit 3 protects the high nibble from data writes and bit 2 protects the low nibble. Bit 1 forces `disp_hi_o` to 0 and bit 0 forces `disp_lo_o` to 0.
- R11: Opcode 101 with bit 1 set zeroes the whole display memory. With bit 0 set it empties the queue and clears overrun and the interrupt. Each bit acts alone.
- R12: Opcode 010 selects display reads, with the start address in bits 2:0 and auto-increment in bit 4. Data reads then return display memory and never remove queue entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low; one access per cycle held low |
| wr_n | input | 1 | Write strobe, active low; one access per cycle held low |
| a0 | input | 1 | 1 = command write / status read, 0 = data |
| din | input | 8 | Host write byte |
| dout | output | 8 | Host read byte |
| scan_o | output | 8 | Column select, encoded or one-hot |
| ret_i | input | 8 | Return lines, low = key closed |
| shift_i | input | 1 | Shift key level |
| ctrl_i | input | 1 | Control key level |
| disp_hi_o | output | 4 | High nibble for the current digit |
| disp_lo_o | output | 4 | Low nibble for the current digit |
| irq_o | output | 1 | Key-available interrupt request |

## Verification
The assertions assume that every host access lasts exactly one cycle and that reads and writes never coincide. They also assume that the return lines are a function of the current column and hold steady for the whole dwell, and that a key never reaches a full queue in the same cycle as a queue clear.

The bench drives each strobe between falling edges for a single cycle. It derives the return lines combinationally from `scan_o` through a key-matrix model, so they follow the column exactly. It issues no clear while a key is being held.

Random key positions and modifiers, plus random display bytes, are checked against codes and contents computed in the bench. Directed cases cover a single-visit glitch, held keys, two keys in one column, overrun, masking, blanking and the reduced scan.

// File: rtl/kds_pkg.sv
// Package kds_pkg
// Shared constants and the command opcode type for the keyboard/display
// scan controller. Assumes a byte-wide host port.
package kds_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_MODE    = 3'd0,
        OP_RD_FIFO = 3'd1,
        OP_RD_DISP = 3'd2,
        OP_WR_DISP = 3'd3,
        OP_MASK    = 3'd4,
        OP_CLEAR   = 3'd5,
        OP_EOI     = 3'd6,
        OP_NONE    = 3'd7
    } op_e;
endpackage

// File: rtl/kds_scan.sv
// Module kds_scan
// Column counter shared by the key matrix and the display. Each column is
// held for DWELL cycles; sample_o marks the last cycle of a dwell, when the
// return lines are read and the counter steps. Assumes DWELL >= 2.
module kds_scan #(
    parameter int SCAN_W = 3,
    parameter int DWELL  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     decoded_i,
    input  logic                     half_i,
    output logic [SCAN_W-1:0]        row_o,
    output logic [(1<<SCAN_W)-1:0]   scan_o,
    output logic                     sample_o
);
    localparam int NCOL = 1 << SCAN_W;
    localparam int HALF = NCOL / 2;
    localparam int PW   = (DWELL > 1) ? $clog2(DWELL) : 1;

    logic [PW-1:0]     presc_q;
    logic [SCAN_W-1:0] row_q;

    assign sample_o = (presc_q == PW'(DWELL - 1));
    assign row_o    = row_q;

    // Dwell prescaler: counts cycles within one column.
    always_ff @(posedge clk) begin
        if (!rst_n)        presc_q <= '0;
        else if (sample_o) presc_q <= '0;
        else               presc_q <= presc_q + 1'b1;
    end

    // Column counter: steps at dwell end, wrapping early in half mode.
    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else if (sample_o)
            row_q <= (half_i && row_q >= SCAN_W'(HALF - 1)) ? '0 : row_q + 1'b1;
    end

    // Output form: one-hot in decoded mode, binary count otherwise.
    always_comb begin
        scan_o = '0;
        if (decoded_i) scan_o[row_q] = 1'b1;
        else           scan_o[SCAN_W-1:0] = row_q;
    end

    assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_o |=> $stable(row_q));
    assert_half_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && half_i) |=> (row_q < SCAN_W'(HALF)));
    assert_dwell_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);
endmodule

// File: rtl/kds_keys.sv
// Module kds_keys
// Debounce and encoding. For each matrix position it keeps "seen closed on
// the last visit" and "already queued". A key is reported when it is closed
// now and was closed on the previous visit and is not yet reported; the
// lowest such return line wins, one per visit. Assumes ret_i is steady
// during the dwell.
module kds_keys #(
    parameter int SCAN_W = 3,
    parameter int RET_W  = 8,
    localparam int COL_W  = $clog2(RET_W),
    localparam int CODE_W = 2 + SCAN_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic [SCAN_W-1:0] row_i,
    input  logic [RET_W-1:0]  ret_i,
    input  logic              shift_i,
    input  logic              ctrl_i,
    output logic              push_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int NCOL = 1 << SCAN_W;

    logic [RET_W-1:0] seen_q [NCOL];
    logic [RET_W-1:0] rept_q [NCOL];
    logic [RET_W-1:0] closed, cand, pick_oh;
    logic [COL_W-1:0] pick;
    logic             found;

    // Candidate selection: lowest debounced, unreported closed line.
    always_comb begin
        closed = ~ret_i;
        cand   = closed & seen_q[row_i] & ~rept_q[row_i];
        found  = 1'b0;
        pick   = '0;
        for (int i = RET_W - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                pick  = COL_W'(i);
            end
        end
        pick_oh = found ? (RET_W'(1) << pick) : '0;
    end

    // Per-column history update and registered key output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCOL; k++) begin
                seen_q[k] <= '0;
                rept_q[k] <= '0;
            end
            push_o <= 1'b0;
            code_o <= '0;
        end else begin
            push_o <= sample_i && found;
            if (sample_i) begin
                seen_q[row_i] <= closed;
                rept_q[row_i] <= (rept_q[row_i] & closed) | pick_oh;
                code_o        <= {shift_i, ctrl_i, row_i, pick};
            end
        end
    end

    assert_one_key_per_visit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);
endmodule

// File: rtl/kds_fifo.sv
// Module kds_fifo
// Key queue. Writes are accepted only when not full; a write against a full
// queue sets a sticky overrun flag. Clear empties it and drops overrun.
// Assumes pop_i is only raised when the queue is not empty.
module kds_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_i,
    input  logic          clear_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o,
    output logic          empty_o,
    output logic          ovr_o,
    output logic          acc_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          ovr_q, full, take;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign acc_o   = push_i && !full && !clear_i;
    assign take    = pop_i && !empty_o && !clear_i;
    assign head_o  = mem[rp_q];
    assign count_o = cnt_q;
    assign ovr_o   = ovr_q;

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (acc_o) mem[wp_q] <= data_i;
    end

    // Pointers, fill count and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (acc_o) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (take)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(acc_o) - CW'(take);
            if (push_i && full) ovr_q <= 1'b1;
        end
    end

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !clear_i) |=> ovr_q);
    assert_empty_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/kds_ctrl.sv
// Module kds_ctrl
// Host port, command decoder, display memory, nibble masking/blanking and
// the interrupt flag. Each cycle with cs_n and a strobe low is one access;
// assumes the host never reads and writes in the same cycle.
module kds_ctrl
    import kds_pkg::*;
#(
    parameter int SCAN_W = 3,
    parameter int CW     = 4,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              a0,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    input  logic [SCAN_W-1:0] row_i,
    input  logic [CODE_W-1:0] fifo_head_i,
    input  logic [CW-1:0]     fifo_cnt_i,
    input  logic              fifo_empty_i,
    input  logic              fifo_ovr_i,
    input  logic              key_acc_i,
    output logic              pop_o,
    output logic              fifo_clr_o,
    output logic              decoded_o,
    output logic              half_o,
    output logic [3:0]        disp_hi_o,
    output logic [3:0]        disp_lo_o,
    output logic              irq_o
);
    localparam int NCOL = 1 << SCAN_W;

    op_e               op;
    logic              cmd_wr, dat_wr, dat_rd;
    logic              dec_q, half_q, rsel_q, rai_q, wai_q;
    logic [SCAN_W-1:0] raddr_q, waddr_q;
    logic              inh_hi_q, inh_lo_q, blk_hi_q, blk_lo_q, irq_q;
    logic [BYTE_W-1:0] dram_q [NCOL];
    logic [BYTE_W-1:0] cur, status;

    assign op         = op_e'(din[7:5]);
    assign cmd_wr     = !cs_n && !wr_n && a0;
    assign dat_wr     = !cs_n && !wr_n && !a0;
    assign dat_rd     = !cs_n && !rd_n && !a0;
    assign pop_o      = dat_rd && !rsel_q && !fifo_empty_i;
    assign fifo_clr_o = cmd_wr && (op == OP_CLEAR) && din[0];
    assign decoded_o  = dec_q;
    assign half_o     = half_q;
    assign irq_o      = irq_q;

    // Command registers and read/write address pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= 1'b0; half_q <= 1'b0; rsel_q <= 1'b0; rai_q <= 1'b0;
            wai_q <= 1'b0; raddr_q <= '0; waddr_q <= '0;
            inh_hi_q <= 1'b0; inh_lo_q <= 1'b0; blk_hi_q <= 1'b0; blk_lo_q <= 1'b0;
        end else begin
            if (cmd_wr) begin
                case (op)
                    OP_MODE: begin
                        dec_q  <= din[0];
                        half_q <= (din[4:3] == 2'b01);
                    end
                    OP_RD_FIFO: rsel_q <= 1'b0;
                    OP_RD_DISP: begin
                        rsel_q  <= 1'b1;
                        rai_q   <= din[4];
                        raddr_q <= din[SCAN_W-1:0];
                    end
                    OP_WR_DISP: begin
                        wai_q   <= din[4];
                        waddr_q <= din[SCAN_W-1:0];
                    end
                    OP_MASK: begin
                        inh_hi_q <= din[3];
                        inh_lo_q <= din[2];
                        blk_hi_q <= din[1];
                        blk_lo_q <= din[0];
                    end
                    default: ;
                endcase
            end
            if (dat_wr && wai_q)           waddr_q <= waddr_q + 1'b1;
            if (dat_rd && rsel_q && rai_q) raddr_q <= raddr_q + 1'b1;
        end
    end

    // Display memory: clear command or nibble-masked data write.
    always_ff @(posedge clk) begin
        if (!rst_n || (cmd_wr && op == OP_CLEAR && din[1])) begin
            for (int k = 0; k < NCOL; k++) dram_q[k] <= '0;
        end else if (dat_wr) begin
            dram_q[waddr_q] <= {inh_hi_q ? dram_q[waddr_q][7:4] : din[7:4],
                                inh_lo_q ? dram_q[waddr_q][3:0] : din[3:0]};
        end
    end

    // Interrupt flag: set by an accepted key, dropped by acknowledge or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    irq_q <= 1'b0;
        else if (key_acc_i)                            irq_q <= 1'b1;
        else if (fifo_clr_o || (cmd_wr && op == OP_EOI)) irq_q <= 1'b0;
    end

    // Host read mux: status, display memory or queue head.
    always_comb begin
        status = {fifo_ovr_i, {(BYTE_W - 1 - CW){1'b0}}, fifo_cnt_i};
        if (a0)               dout = status;
        else if (rsel_q)      dout = dram_q[raddr_q];
        else if (fifo_empty_i) dout = '0;
        else                  dout = BYTE_W'(fifo_head_i);
    end

    // Digit output with per-half blanking.
    always_comb begin
        cur       = dram_q[row_i];
        disp_hi_o = blk_hi_q ? 4'h0 : cur[7:4];
        disp_lo_o = blk_lo_q ? 4'h0 : cur[3:0];
    end

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(key_acc_i));
    assert_irq_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && op == OP_EOI && !key_acc_i) |=> !irq_q);
endmodule

// File: rtl/kbd_disp_scanner.sv
// Module kbd_disp_scanner
// Top level: shared scan counter, key debounce/encode, key queue and host
// control. Assumes 2 + SCAN_W + log2(RET_W) <= 8 so a key code fits a byte.
module kbd_disp_scanner #(
    parameter int SCAN_W     = 3,
    parameter int RET_W      = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int DWELL      = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic                   a0,
    input  logic [7:0]             din,
    output logic [7:0]             dout,
    output logic [(1<<SCAN_W)-1:0] scan_o,
    input  logic [RET_W-1:0]       ret_i,
    input  logic                   shift_i,
    input  logic                   ctrl_i,
    output logic [3:0]             disp_hi_o,
    output logic [3:0]             disp_lo_o,
    output logic                   irq_o
);
    localparam int CODE_W = 2 + SCAN_W + $clog2(RET_W);
    localparam int CW     = $clog2(FIFO_DEPTH + 1);

    logic [SCAN_W-1:0] row;
    logic              sample, decoded, half, push, pop, fclr, acc, fempty, fovr;
    logic [CODE_W-1:0] code, head;
    logic [CW-1:0]     fcnt;

    kds_scan #(.SCAN_W(SCAN_W), .DWELL(DWELL)) u_scan (
        .clk(clk), .rst_n(rst_n), .decoded_i(decoded), .half_i(half),
        .row_o(row), .scan_o(scan_o), .sample_o(sample)
    );

    kds_keys #(.SCAN_W(SCAN_W), .RET_W(RET_W)) u_keys (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .row_i(row), .ret_i(ret_i),
        .shift_i(shift_i), .ctrl_i(ctrl_i), .push_o(push), .code_o(code)
    );

    kds_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(code), .pop_i(pop),
        .clear_i(fclr), .head_o(head), .count_o(fcnt), .empty_o(fempty),
        .ovr_o(fovr), .acc_o(acc)
    );

    kds_ctrl #(.SCAN_W(SCAN_W), .CW(CW), .CODE_W(CODE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
        .din(din), .dout(dout), .row_i(row), .fifo_head_i(head), .fifo_cnt_i(fcnt),
        .fifo_empty_i(fempty), .fifo_ovr_i(fovr), .key_acc_i(acc), .pop_o(pop),
        .fifo_clr_o(fclr), .decoded_o(decoded), .half_o(half),
        .disp_hi_o(disp_hi_o), .disp_lo_o(disp_lo_o), .irq_o(irq_o)
    );
endmodule

// File: tb/sim_kbd_disp_scanner.sv
module sim_kbd_disp_scanner;
    localparam int SCAN = 32;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic       shift_i = 1'b0, ctrl_i = 1'b0;
    logic [7:0] din = 8'h00, dout, scan_o, ret_i;
    logic [3:0] disp_hi_o, disp_lo_o;
    logic       irq_o;
    logic [7:0] keymat [8];
    bit         dec_mode = 1'b0;
    bit         done = 1'b0;
    int         cur_row;
    int         tests = 0, fails = 0;
    logic [7:0] expq [$];

    kbd_disp_scanner u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
        .din(din), .dout(dout), .scan_o(scan_o), .ret_i(ret_i), .shift_i(shift_i),
        .ctrl_i(ctrl_i), .disp_hi_o(disp_hi_o), .disp_lo_o(disp_lo_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    // Key matrix model: return lines follow the selected column.
    always_comb begin
        cur_row = 0;
        if (dec_mode) begin
            for (int i = 0; i < 8; i++) if (scan_o[i]) cur_row = i;
        end else cur_row = int'(scan_o[2:0]);
        ret_i = ~keymat[cur_row[2:0]];
    end

    function automatic logic [7:0] kcode(bit sh, bit ct, int r, int c);
        return {sh, ct, 3'(r), 3'(c)};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk); cs_n = 0; wr_n = 0; a0 = sel; din = d;
        @(negedge clk); cs_n = 1; wr_n = 1;
    endtask

    task automatic rd(bit sel, output logic [7:0] v);
        @(negedge clk); cs_n = 0; rd_n = 0; a0 = sel;
        #1 v = dout;
        @(negedge clk); cs_n = 1; rd_n = 1;
    endtask

    task automatic press(int r, int c, bit sh, bit ct);
        keymat[r][c] = 1'b1; shift_i = sh; ctrl_i = ct;
        idle(3 * SCAN + 8);
        keymat[r][c] = 1'b0;
        idle(SCAN + 8);
        shift_i = 0; ctrl_i = 0;
    endtask

    task automatic wait_row(int r);
        int g;
        g = 0;
        while (cur_row != r && g < 200) begin @(negedge clk); g++; end
    endtask

    // Watch column steps: period 4, +1 modulo lim, one-hot when decoded.
    task automatic scan_watch(string tag, int ncyc, bit dec, int lim);
        int prev, run, bad;
        bit seen;
        prev = cur_row; run = 0; bad = 0; seen = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            run++;
            if (dec && $countones(scan_o) != 1) bad++;
            if (cur_row >= lim) bad++;
            if (cur_row != prev) begin
                if (seen && run != 4) bad++;
                if (cur_row != (prev + 1) % lim) bad++;
                seen = 1; run = 0; prev = cur_row;
            end
        end
        chk(tag, 8'(bad), 8'h00);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, st, d [8];
        int n, r, c;
        bit sh, ct;
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) keymat[i] = 8'h00;
        idle(5);
        rst_n = 1;
        idle(1);

        // R1 reset state
        chk("R1 scan", scan_o, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        chk("R1 disp", {disp_hi_o, disp_lo_o}, 8'h00);
        rd(1, v); chk("R1 status", v, 8'h00);

        // R2 encoded stepping over all 8 columns
        scan_watch("R2 encoded step", 80, 0, 8);

        // R3/R4/R5/R6/R7 single key
        press(3, 6, 1, 0);
        rd(1, v); chk("R6 count one", v, 8'h01);
        chk("R7 irq set", {7'b0, irq_o}, 8'h01);
        rd(0, v); chk("R4 code", v, kcode(1, 0, 3, 6));
        chk("R7 irq held after read", {7'b0, irq_o}, 8'h01);
        rd(1, v); chk("R5 drained", v, 8'h00);
        rd(0, v); chk("R5 empty read", v, 8'h00);
        rd(1, v); chk("R5 empty read no change", v, 8'h00);
        wr(1, 8'hC0); idle(1);
        chk("R7 eoi clears", {7'b0, irq_o}, 8'h00);

        // R3 seen on a single visit only: not queued
        wait_row(5); keymat[5][2] = 1'b1;
        while (cur_row == 5) @(negedge clk);
        keymat[5][2] = 1'b0;
        idle(3 * SCAN);
        rd(1, v); chk("R3 single visit ignored", v, 8'h00);

        // R3 held key queued once
        keymat[1][4] = 1'b1; idle(6 * SCAN); keymat[1][4] = 1'b0; idle(SCAN + 8);
        rd(1, v); chk("R3 held once", v, 8'h01);
        rd(0, v); chk("R3 held code", v, kcode(0, 0, 1, 4));

        // R4 two keys in one column: lowest index first
        keymat[2][5] = 1'b1; keymat[2][1] = 1'b1; ctrl_i = 1;
        idle(5 * SCAN);
        keymat[2] = 8'h00; idle(SCAN + 8); ctrl_i = 0;
        rd(1, v); chk("R4 two keys count", v, 8'h02);
        rd(0, v); chk("R4 lowest first", v, kcode(0, 1, 2, 1));
        rd(0, v); chk("R4 second key", v, kcode(0, 1, 2, 5));

        // R6 overrun: nine keys into an eight-entry queue
        wr(1, 8'hA1);
        for (int i = 0; i < 9; i++) press(i % 8, (i * 3) % 8, 0, 0);
        rd(1, v); chk("R6 full plus overrun", v, 8'h88);
        for (int i = 0; i < 8; i++) begin
            rd(0, v); chk("R5 order after overrun", v, kcode(0, 0, i % 8, (i * 3) % 8));
        end
        rd(1, v); chk("R6 overrun sticky", v, 8'h80);
        wr(1, 8'hA1); idle(1);
        rd(1, v); chk("R11 queue clear status", v, 8'h00);
        chk("R11 queue clear irq", {7'b0, irq_o}, 8'h00);

        // R9/R12 display writes and reads, queue untouched
        press(6, 0, 0, 1);
        wr(1, 8'h70);
        for (int i = 0; i < 8; i++) begin
            d[i] = 8'($urandom);
            wr(0, d[i]);
        end
        for (int i = 0; i < 8; i += 3) begin
            wait_row(i); chk("R9 digit out", {disp_hi_o, disp_lo_o}, d[i]);
        end
        wr(1, 8'h50);
        for (int i = 0; i < 8; i++) begin
            rd(0, v); chk("R12 display read", v, d[i]);
        end
        rd(1, v); chk("R12 queue kept", v, 8'h01);
        wr(1, 8'h20);
        rd(0, v); chk("R12 queue after reselect", v, kcode(0, 1, 6, 0));

        // R10 inhibit and blank
        wr(1, 8'h63); wr(0, 8'hA5);
        wr(1, 8'h88); wr(1, 8'h63); wr(0, 8'h3C);
        wr(1, 8'h80); wait_row(3);
        chk("R10 inhibit high", {disp_hi_o, disp_lo_o}, 8'hAC);
        wr(1, 8'h84); wr(1, 8'h63); wr(0, 8'h77);
        wr(1, 8'h81); wait_row(3);
        chk("R10 blank low", {disp_hi_o, disp_lo_o}, 8'h70);
        wr(1, 8'h82); wait_row(3);
        chk("R10 blank high", {disp_hi_o, disp_lo_o}, 8'h0C);
        wr(1, 8'h80);
        wr(1, 8'h43); rd(0, v); chk("R10 inhibit low stored", v, 8'h7C);
        wr(1, 8'h20);

        // R8 opcode 111 has no effect
        press(7, 7, 1, 1);
        rd(1, st);
        wr(1, 8'hFF); idle(1);
        rd(1, v); chk("R8 no-op status", v, st);
        chk("R8 no-op irq", {7'b0, irq_o}, 8'h01);
        wait_row(3); chk("R8 no-op display", {disp_hi_o, disp_lo_o}, 8'h7C);

        // R11 display clear alone keeps queue
        wr(1, 8'hA2);
        wr(1, 8'h50);
        for (int i = 0; i < 8; i++) begin
            rd(0, v); chk("R11 display zeroed", v, 8'h00);
        end
        wr(1, 8'h20);
        rd(1, v); chk("R11 queue kept", v, 8'h01);
        rd(0, v); chk("R11 queued code", v, kcode(1, 1, 7, 7));
        wr(1, 8'hC0);

        // R2 decoded, reduced and combined scan forms
        wr(1, 8'h01); dec_mode = 1; idle(SCAN);
        scan_watch("R2 decoded step", 80, 1, 8);
        press(5, 2, 0, 0);
        rd(0, v); chk("R2 key in decoded form", v, kcode(0, 0, 5, 2));
        wr(1, 8'h09); idle(SCAN);
        scan_watch("R2 decoded half", 64, 1, 4);
        wr(1, 8'h08); dec_mode = 0; idle(SCAN);
        scan_watch("R2 encoded half", 64, 0, 4);
        wr(1, 8'h00); idle(SCAN);
        wr(1, 8'hC0);

        // Random rounds: keys with modifiers, checked in arrival order
        for (int rr = 0; rr < 6; rr++) begin
            n = 1 + int'($urandom % 8);
            for (int k = 0; k < n; k++) begin
                r = int'($urandom % 8); c = int'($urandom % 8);
                sh = 1'($urandom); ct = 1'($urandom);
                press(r, c, sh, ct);
                expq.push_back(kcode(sh, ct, r, c));
            end
            rd(1, v); chk("R6 random count", v, 8'(n));
            chk("R7 random irq", {7'b0, irq_o}, 8'h01);
            for (int k = 0; k < n; k++) begin
                rd(0, v); chk("R4 random code", v, expq.pop_front());
            end
            wr(1, 8'hC0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule